// File: doc/BRIEF.md
# Single-Bank DRAM Command Scheduler with Selectable Row Policy

This block turns a stream of read and write requests, each addressed by row and column, into a legal command sequence for one DRAM bank. It remembers which row sits in the row buffer. It opens rows with an activate command and closes them with a precharge command. It keeps the minimum cycle spacing between dependent commands. It also injects a refresh whenever the refresh interval runs out. At most one command leaves the block per cycle. A request is acknowledged in the cycle its column command issues.

A static configuration input chooses how the row buffer is managed. In the open-row mode, a row stays open after an access and is closed only when a request for another row must be served or a refresh is due. In the closed-row mode, the row is closed as soon as timing allows after each access. The exception is a pending request queued behind the current one that targets the same row, which keeps the row open for it. The requester presents that queued request on lookahead inputs. A refresh takes precedence over everything else: an open row is closed first, and the bank stays silent for the whole refresh recovery time.

Top module: `bank_sched`

## Requirements
- R1: While reset is asserted and in the cycles after its release with no request, the command output is NOP (0), and neither `req_ready` nor `row_hit` is high.
- R2: A column command (READ or WRITE) issues only to the open row and no sooner than T_RCD cycles after the ACTIVATE of that row. From an idle bank, a request gets ACTIVATE in its first cycle and its column command exactly T_RCD cycles later.
- R3: ACTIVATE issues only while no row is open and at least T_RP cycles after the last PRECHARGE. PRECHARGE issues only while a row is open and at least T_RAS cycles after its ACTIVATE. A request to a different row therefore waits max(0, T_RAS-T_RCD-2)+T_RP+T_RCD cycles when it follows two back-to-back accesses to a freshly opened row.
- R4: REFRESH issues only while the bank is closed and at least T_RP cycles after the last PRECHARGE. No more than T_REFI+T_RAS+T_RP+4 cycles pass between reset release and the first REFRESH, or between consecutive REFRESH commands.
- R5: For T_RFC cycles after a REFRESH, no other command issues.
- R6: In open-row mode, a PRECHARGE is followed by a REFRESH or by an ACTIVATE of a different row as its next command.
- R7: In closed-row mode, when the lookahead request after a column command is absent or targets another row, the next command is PRECHARGE. It issues within T_RAS cycles of the column command.
- R8: In closed-row mode, when the lookahead request targets the same row, the row stays open. The next command is that row's column command, unless a refresh forces a PRECHARGE, which is then followed directly by REFRESH.
- R9: A request to the row already open issues its column command in its first cycle once timing allows, with `row_hit` high. A request that needed an ACTIVATE has `row_hit` low.
- R10: `req_ready` is high exactly in the cycle of the request's column command. Commands are encoded NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, REFRESH=5. A high `req_write` selects WRITE. `cmd_row` carries the row on ACTIVATE and on column commands, and `cmd_col` carries the request's column on column commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| closed_policy | input | 1 | 1 selects closed-row mode, 0 selects open-row mode |
| req_valid | input | 1 | Current request present; held until acknowledged |
| req_write | input | 1 | 1 for write, 0 for read |
| req_row | input | ROW_W | Row of the current request |
| req_col | input | COL_W | Column of the current request |
| next_valid | input | 1 | A further request is queued behind the current one |
| next_row | input | ROW_W | Row of the queued request |
| req_ready | output | 1 | Acknowledge, high in the column-command cycle |
| cmd | output | 3 | Command issued this cycle |
| cmd_row | output | ROW_W | Row of the issued command |
| cmd_col | output | COL_W | Column of the issued command |
| row_hit | output | 1 | Column command served without an activate for this request |

## Verification
The hardest case to reach from the ports is a refresh that becomes due while a row is open. It matters most when this happens inside the T_RAS window, or right after a closed-row access whose lookahead matched the same row. Only then does the scheduler have to delay a precharge it would never issue on its own, and hold back a request that would otherwise hit. The stimulus reaches this case through long random request streams with short gaps and only four rows in use. These streams run in both policies across many refresh intervals, so refreshes land at varied points of the row cycle. A directed idle stretch with a row left open forces the close-then-refresh path. A protocol monitor in the bench rebuilds the bank state from the command output, checks every command against the timing and policy rules, and checks each acknowledge against the request that was presented.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } dram_cmd_e;

  localparam int NUM_GAPS = 4;
  localparam int GAP_RCD  = 0;
  localparam int GAP_RAS  = 1;
  localparam int GAP_RP   = 2;
  localparam int GAP_RFC  = 3;

endpackage

// File: rtl/bank_gap_timer.sv
module bank_gap_timer #(
  parameter int LOAD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int CNT_W = (LOAD > 1) ? $clog2(LOAD) : 1;
  localparam logic [CNT_W-1:0] LOAD_M1 = (LOAD > 1) ? CNT_W'(LOAD - 1) : '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load || (cnt_q != '0);
    if (load)
      cnt_d = LOAD_M1;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/bank_refresh_tracker.sv
module bank_refresh_tracker #(
  parameter int T_REFI = 220
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_issued,
  output logic ref_due
);

  localparam int IW = $clog2(T_REFI + 1);
  localparam logic [IW-1:0] LAST = IW'(T_REFI - 1);

  logic [IW-1:0] ivl_q, ivl_d;
  logic          wrap;
  logic          due_q, due_d;

  always_comb begin
    wrap  = (ivl_q == LAST);
    ivl_d = wrap ? '0 : ivl_q + 1'b1;
    due_d = wrap || (due_q && !ref_issued);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q <= '0;
      due_q <= 1'b0;
    end else begin
      ivl_q <= ivl_d;
      due_q <= due_d;
    end
  end

  assign ref_due = due_q;

  // R4: a served refresh clears the request unless a new interval ends at once
  assert_due_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_issued && !wrap) |=> !ref_due);

endmodule

// File: rtl/bank_row_fsm.sv
module bank_row_fsm
  import bank_sched_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             closed_policy,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             next_valid,
  input  logic [ROW_W-1:0] next_row,
  input  logic             ref_due,
  input  logic             rcd_ok,
  input  logic             ras_ok,
  input  logic             rp_ok,
  input  logic             rfc_ok,
  output dram_cmd_e        cmd,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             req_ready,
  output logic             row_hit
);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             close_q, close_d;
  logic             fresh_q, fresh_d;
  logic             st_en;
  logic             hit;
  logic             keep_for_next;

  // command selection: refresh first, then hits, then closing, then opening
  always_comb begin
    cmd       = CMD_NOP;
    cmd_row   = row_q;
    cmd_col   = '0;
    req_ready = 1'b0;
    row_hit   = 1'b0;
    hit       = open_q && (req_row == row_q);
    if (!rfc_ok) begin
      cmd = CMD_NOP;
    end else if (ref_due) begin
      if (open_q) begin
        if (ras_ok) cmd = CMD_PRE;
      end else if (rp_ok) begin
        cmd = CMD_REF;
      end
    end else if (req_valid && hit) begin
      if (rcd_ok) begin
        cmd       = req_write ? CMD_WR : CMD_RD;
        cmd_col   = req_col;
        req_ready = 1'b1;
        row_hit   = !fresh_q;
      end
    end else if (open_q && (close_q || req_valid)) begin
      if (ras_ok) cmd = CMD_PRE;
    end else if (req_valid && !open_q) begin
      if (rp_ok) begin
        cmd     = CMD_ACT;
        cmd_row = req_row;
      end
    end
  end

  always_comb begin
    keep_for_next = next_valid && (next_row == req_row);
    open_d  = open_q;
    row_d   = row_q;
    close_d = close_q;
    fresh_d = fresh_q;
    st_en   = (cmd != CMD_NOP);
    case (cmd)
      CMD_ACT: begin
        open_d  = 1'b1;
        row_d   = req_row;
        fresh_d = 1'b1;
        close_d = 1'b0;
      end
      CMD_RD, CMD_WR: begin
        fresh_d = 1'b0;
        close_d = closed_policy && !keep_for_next;
      end
      CMD_PRE: begin
        open_d  = 1'b0;
        close_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      row_q   <= '0;
      close_q <= 1'b0;
      fresh_q <= 1'b0;
    end else if (st_en) begin
      open_q  <= open_d;
      row_q   <= row_d;
      close_q <= close_d;
      fresh_q <= fresh_d;
    end
  end

  // R2: column access only to an open row after the activate delay
  assert_col_after_rcd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> (open_q && rcd_ok));

  // R2: an activate leaves a row open
  assert_act_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> open_q);

  // R3: precharge respects the active window
  assert_pre_after_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |-> (open_q && ras_ok));

  // R3: activate only on a closed, recovered bank
  assert_act_after_rp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |-> (!open_q && rp_ok));

  // R4: refresh only when owed and with the bank closed
  assert_ref_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |-> (!open_q && ref_due && rp_ok));

  // R5: silence during refresh recovery
  assert_quiet_in_rfc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rfc_ok |-> (cmd == CMD_NOP));

  // R10: acknowledge coincides with a column command
  assert_ack_on_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd == CMD_RD || cmd == CMD_WR));

endmodule

// File: rtl/bank_sched.sv
module bank_sched
  import bank_sched_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int T_RCD  = 3,
  parameter int T_RAS  = 7,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 9,
  parameter int T_REFI = 220
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             closed_policy,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             next_valid,
  input  logic [ROW_W-1:0] next_row,
  output logic             req_ready,
  output logic [2:0]       cmd,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             row_hit
);

  localparam int GAP_LOAD [NUM_GAPS] = '{T_RCD, T_RAS, T_RP, T_RFC};

  logic [1:0]          rst_pipe;
  logic                rst_s_n;
  dram_cmd_e           cmd_e;
  logic [NUM_GAPS-1:0] gap_load;
  logic [NUM_GAPS-1:0] gap_done;
  logic                ref_due;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  always_comb begin
    gap_load          = '0;
    gap_load[GAP_RCD] = (cmd_e == CMD_ACT);
    gap_load[GAP_RAS] = (cmd_e == CMD_ACT);
    gap_load[GAP_RP]  = (cmd_e == CMD_PRE);
    gap_load[GAP_RFC] = (cmd_e == CMD_REF);
  end

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    bank_gap_timer #(.LOAD(GAP_LOAD[g])) u_gap (
      .clk   (clk),
      .rst_n (rst_s_n),
      .load  (gap_load[g]),
      .done  (gap_done[g])
    );
  end

  bank_refresh_tracker #(.T_REFI(T_REFI)) u_refresh (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .ref_issued (cmd_e == CMD_REF),
    .ref_due    (ref_due)
  );

  bank_row_fsm #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .closed_policy (closed_policy),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_row       (req_row),
    .req_col       (req_col),
    .next_valid    (next_valid),
    .next_row      (next_row),
    .ref_due       (ref_due),
    .rcd_ok        (gap_done[GAP_RCD]),
    .ras_ok        (gap_done[GAP_RAS]),
    .rp_ok         (gap_done[GAP_RP]),
    .rfc_ok        (gap_done[GAP_RFC]),
    .cmd           (cmd_e),
    .cmd_row       (cmd_row),
    .cmd_col       (cmd_col),
    .req_ready     (req_ready),
    .row_hit       (row_hit)
  );

  assign cmd = cmd_e;

  // R1: nothing is issued while the synchronized reset is held
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_s_n |-> (cmd == 3'd0 && !req_ready));

endmodule

// File: tb/bank_sched_tb.sv
`timescale 1ns/1ps
module bank_sched_tb;

  localparam int ROW_W  = 8;
  localparam int COL_W  = 6;
  localparam int T_RCD  = 3;
  localparam int T_RAS  = 7;
  localparam int T_RP   = 3;
  localparam int T_RFC  = 9;
  localparam int T_REFI = 220;
  localparam int REF_BOUND = T_REFI + T_RAS + T_RP + 4;
  localparam int NRAND = 400;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2,
                         C_WR  = 3'd3, C_PRE = 3'd4, C_REF = 3'd5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             closed_policy;
  logic             req_valid, req_write;
  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             next_valid;
  logic [ROW_W-1:0] next_row;
  logic             req_ready;
  logic [2:0]       cmd;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic             row_hit;

  always #2.5 clk = ~clk;

  bank_sched #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
               .T_RP(T_RP), .T_RFC(T_RFC), .T_REFI(T_REFI)) u_dut (
    .clk(clk), .rst_n(rst_n), .closed_policy(closed_policy),
    .req_valid(req_valid), .req_write(req_write), .req_row(req_row),
    .req_col(req_col), .next_valid(next_valid), .next_row(next_row),
    .req_ready(req_ready), .cmd(cmd), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .row_hit(row_hit));

  int checks = 0;
  int fails  = 0;
  // monitor state rebuilt from the command stream
  int cyc = 0;
  int last_act = -1000, last_pre = -1000, last_ref = 0, last_col = -1000;
  bit b_open = 0;
  logic [ROW_W-1:0] b_row = '0, closed_row = '0;
  bit act_seen = 0;
  bit last_hit = 0;
  bit ref_late_flagged = 0;
  int ref_count = 0;
  // 0 free, 1 PRE must follow, 2 column (or refresh PRE) must follow,
  // 3 REF or ACT of other row must follow, 4 REF must follow
  int exp_next = 0;

  logic [ROW_W-1:0] r_row [NRAND];
  logic [COL_W-1:0] r_col [NRAND];
  bit               r_wr  [NRAND];
  int               r_gap [NRAND];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at sample %0d: actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  task automatic check_cycle();
    cyc++;
    if (cyc - last_ref > REF_BOUND && !ref_late_flagged) begin
      ref_late_flagged = 1;
      chk(0, "R4 refresh overdue", cyc - last_ref, REF_BOUND);
    end
    if (req_ready) chk(cmd == C_RD || cmd == C_WR, "R10 ack without column", cmd, C_RD);
    if (cmd != C_NOP) chk(cyc - last_ref >= T_RFC || ref_count == 0, "R5 command in refresh", cyc - last_ref, T_RFC);
    case (cmd)
      C_NOP: begin
        if (exp_next == 1 && cyc - last_col > T_RAS) begin
          chk(0, "R7 close late", cyc - last_col, T_RAS);
          exp_next = 0;
        end
      end
      C_ACT: begin
        chk(!b_open, "R3 act on open bank", b_open, 0);
        chk(cyc - last_pre >= T_RP, "R3 act before tRP", cyc - last_pre, T_RP);
        chk(req_valid && cmd_row == req_row, "R10 act row", cmd_row, req_row);
        if (exp_next == 1) chk(0, "R7 expected PRE", cmd, C_PRE);
        if (exp_next == 2) chk(0, "R8 expected column", cmd, C_RD);
        if (exp_next == 4) chk(0, "R8 expected REF", cmd, C_REF);
        if (exp_next == 3) chk(cmd_row != closed_row, "R6 reopened same row", cmd_row, closed_row);
        exp_next = 0;
        b_open = 1; b_row = cmd_row; last_act = cyc; act_seen = 1;
      end
      C_RD, C_WR: begin
        chk(b_open && cmd_row == b_row, "R2 column row", cmd_row, b_row);
        chk(cyc - last_act >= T_RCD, "R2 column before tRCD", cyc - last_act, T_RCD);
        chk(req_valid && req_ready, "R10 ack missing", req_ready, 1);
        chk(cmd_row == req_row && cmd_col == req_col, "R10 column address", cmd_col, req_col);
        chk((cmd == C_WR) == req_write, "R10 read/write", cmd, req_write ? C_WR : C_RD);
        chk(row_hit == !act_seen, "R9 row_hit", row_hit, !act_seen);
        if (exp_next == 1) chk(0, "R7 expected PRE", cmd, C_PRE);
        if (exp_next == 3) chk(0, "R6 expected REF/ACT", cmd, C_ACT);
        if (exp_next == 4) chk(0, "R8 expected REF", cmd, C_REF);
        if (closed_policy) exp_next = (next_valid && next_row == req_row) ? 2 : 1;
        else exp_next = 0;
        last_hit = row_hit; last_col = cyc; act_seen = 0;
      end
      C_PRE: begin
        chk(b_open, "R3 pre on closed bank", b_open, 1);
        chk(cyc - last_act >= T_RAS, "R3 pre before tRAS", cyc - last_act, T_RAS);
        if (exp_next == 1) chk(cyc - last_col <= T_RAS, "R7 close deadline", cyc - last_col, T_RAS);
        if (exp_next == 4) chk(0, "R8 expected REF", cmd, C_REF);
        if (exp_next == 2) exp_next = 4;
        else if (!closed_policy) begin exp_next = 3; closed_row = b_row; end
        else exp_next = 0;
        b_open = 0; last_pre = cyc;
      end
      C_REF: begin
        chk(!b_open, "R4 refresh with open row", b_open, 0);
        chk(cyc - last_pre >= T_RP, "R4 refresh before tRP", cyc - last_pre, T_RP);
        chk(cyc - last_ref <= REF_BOUND, "R4 refresh interval", cyc - last_ref, REF_BOUND);
        if (exp_next == 1) chk(0, "R7 expected PRE", cmd, C_PRE);
        if (exp_next == 2) chk(0, "R8 expected column", cmd, C_RD);
        exp_next = 0;
        last_ref = cyc; ref_count++;
      end
      default: chk(0, "R10 illegal encoding", cmd, 0);
    endcase
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); check_cycle();
      @(posedge clk); #1;
    end
  endtask

  task automatic run_req(input bit w, input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col,
                         input bit nv, input logic [ROW_W-1:0] nrow, input int gap, output int lat);
    bit done;
    req_valid = 1; req_write = w; req_row = row; req_col = col;
    next_valid = nv; next_row = nrow;
    lat = 0; done = 0;
    while (!done) begin
      @(negedge clk); check_cycle();
      if (req_ready) done = 1;
      else begin
        lat++;
        if (lat > 200) begin chk(0, "R10 request never acknowledged", lat, 0); done = 1; end
      end
      @(posedge clk); #1;
    end
    if (gap > 0) begin
      req_valid = 0;
      idle(gap);
    end
  endtask

  initial begin
    #500000;
    chk(0, "R10 watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 0; closed_policy = 0; req_valid = 0; req_write = 0;
    req_row = '0; req_col = '0; next_valid = 0; next_row = '0;
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    chk(cmd == C_NOP && !req_ready && !row_hit, "R1 reset outputs", cmd, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check_cycle();
      chk(cmd == C_NOP && !req_ready && !row_hit, "R1 idle after reset", cmd, 0);
      @(posedge clk); #1;
    end

    // directed, open-row mode
    run_req(0, 8'd5, 6'd1, 1, 8'd5, 0, lat);
    chk(lat == T_RCD, "R2 idle-bank latency", lat, T_RCD);
    chk(last_hit == 0, "R9 miss flag", last_hit, 0);
    run_req(1, 8'd5, 6'd2, 1, 8'd9, 0, lat);
    chk(lat == 0, "R9 hit latency", lat, 0);
    chk(last_hit == 1, "R9 hit flag", last_hit, 1);
    run_req(0, 8'd9, 6'd3, 0, 8'd0, 2, lat);
    chk(lat == ((T_RAS - T_RCD - 2 > 0) ? T_RAS - T_RCD - 2 : 0) + T_RP + T_RCD,
        "R3 row-change latency", lat, ((T_RAS - T_RCD - 2 > 0) ? T_RAS - T_RCD - 2 : 0) + T_RP + T_RCD);
    chk(b_open && b_row == 8'd9, "R6 row left open", b_row, 9);
    idle(REF_BOUND);
    chk(ref_count >= 1, "R4 refresh with open row pending", ref_count, 1);
    chk(!b_open, "R4 row closed for refresh", b_open, 0);

    // directed, closed-row mode
    closed_policy = 1; exp_next = 0;
    run_req(0, 8'd2, 6'd4, 1, 8'd2, 0, lat);
    run_req(1, 8'd2, 6'd5, 1, 8'd3, 0, lat);
    chk(last_hit == 1, "R8 kept row hit", last_hit, 1);
    run_req(0, 8'd3, 6'd6, 0, 8'd0, 12, lat);
    chk(!b_open, "R7 row closed when idle", b_open, 0);

    // random phases: open then closed, rows from a small set
    for (int ph = 0; ph < 2; ph++) begin
      closed_policy = (ph == 1); exp_next = 0;
      for (int i = 0; i < NRAND; i++) begin
        r_row[i] = ROW_W'($urandom_range(0, 3));
        r_col[i] = COL_W'($urandom_range(0, 63));
        r_wr[i]  = 1'($urandom_range(0, 1));
        r_gap[i] = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 4) : 0;
      end
      for (int i = 0; i < NRAND; i++) begin
        run_req(r_wr[i], r_row[i], r_col[i], i + 1 < NRAND,
                (i + 1 < NRAND) ? r_row[i + 1] : '0, r_gap[i], lat);
      end
      req_valid = 0; next_valid = 0;
      idle(20);
    end
    chk(ref_count >= 2, "R4 refreshes during random run", ref_count, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule